// File: doc/BRIEF.md
# Conversion Result Readout Controller

This block is the digital side of an integrating analog-to-digital converter. It holds the latest result as six BCD digits, together with a small set of condition flags. It answers request bytes that a host sends over a byte-wide receive handshake, and each reply goes out as one byte over a transmit handshake. A request selects one of three things: two digits packed into one byte, one digit, or the status byte.

The block also models how long a conversion takes. A start command begins a conversion, and the result appears only after a fixed number of clock cycles. That number depends on two settings: the resolution (5½ or 4½ digits) and whether offset compensation is used.

A simulated digit source takes the place of the integrator's accumulated count. The block copies that source into the readable digit set in one cycle, on the cycle the conversion finishes. It toggles the update flag on that same cycle. A host that reads status before and after fetching digits can therefore tell when a result was replaced in the middle of its read.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, tx_valid is low and rx_ready is high. The status byte reads 0x00 and every digit reads zero.
- R2: A pair request has the form 0000_pp01. For pp = 00, 01 or 10 the reply is one byte: digit 2pp+1 in bits 7:4 and digit 2pp in bits 3:0. For pp = 11 (byte 0x0D) the reply is the status byte.
- R3: A single-digit request has the form 0000_ddd0. For ddd = 0 to 5 the reply is 0000 followed by digit ddd. For ddd = 110 (byte 0x0C) the reply is the status byte.
- R4: The status byte is laid out as follows. Bit 6 is the update flag. Bit 4 is continuity. Bit 3 is resolution (1 = 5½ digits). Bit 2 is conversion type (1 = compensated). Bit 1 is request error. Bit 0 is parity error. Bits 7 and 5 read zero.
- R5: The command byte 0x81 (prefix 100, command field 00001) starts a conversion and samples cfg_res and cfg_comp. The result is published exactly N clock edges after the edge that accepts the command. N is CYC_5C, CYC_5U, CYC_4C or CYC_4U, chosen by {res, comp} = 11, 10, 01 or 00.
- R6: On the publish edge the digits, continuity (taken from src_cont), resolution and type are all updated together, and the update flag toggles. A request accepted on that same edge still sees the old values.
- R7: A start command accepted while a conversion is running has no effect. It changes neither the publish time nor the captured settings.
- R8: An unrecognized byte produces no reply and sets the request error bit. Unrecognized bytes are:
  - bytes whose upper nibble is nonzero and whose top three bits are not 100;
  - command bytes other than 0x81;
  - the pair form ending in 11;
  - the single form with ddd = 111.
- R9: A byte accepted with rx_perr high produces no reply and sets the parity error bit.
- R10: Both error bits stay set until a status byte that reports them completes its transfer. They are cleared on that transfer.
- R11: While a reply is pending, rx_ready is low, and tx_data holds steady until tx_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Request byte present |
| rx_ready | output | 1 | Controller can accept a byte |
| rx_data | input | 8 | Request or command byte |
| rx_perr | input | 1 | Byte arrived with a parity fault |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Host takes the reply byte |
| tx_data | output | 8 | Reply byte |
| cfg_res | input | 1 | Resolution for the next conversion (1 = 5½) |
| cfg_comp | input | 1 | Offset compensation for the next conversion |
| src_digits | input | 24 | Simulated result digits, digit k in bits 4k+3:4k |
| src_cont | input | 1 | Simulated continuity flag |

## Verification
The assertions assume that the host keeps rx_valid meaningful only together with rx_ready. They also assume that the host drives tx_ready for at most one cycle per reply byte. Finally, they assume that src_digits and src_cont hold BCD-legal values that stay fixed for the whole of a conversion. The stimulus meets these assumptions in four ways. It issues one request at a time and drives it only while no reply is pending. It acknowledges each reply with a single tx_ready pulse. It loads new source digits, each drawn from 0 to 9, only while the converter is idle. Random request bytes are mixed with parity faults, but start commands are kept out of the random phase so that the timing of conversions stays directed.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int unsigned NDIG = 6;
    localparam int unsigned DIGW = 4;

    typedef enum logic [2:0] {
        RQ_PAIR,
        RQ_DIGIT,
        RQ_STATUS,
        RQ_START,
        RQ_BAD
    } rq_kind_e;

    typedef struct packed {
        rq_kind_e   kind;
        logic [2:0] idx;
    } rq_t;

    function automatic logic [7:0] pack_status(
        input logic upd,
        input logic cont,
        input logic res,
        input logic comp,
        input logic rerr,
        input logic perr
    );
        return {1'b0, upd, 1'b0, cont, res, comp, rerr, perr};
    endfunction

endpackage

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
    import adc_rd_pkg::*;
#(
    parameter logic [4:0] START_CODE = 5'h01
) (
    input  logic [7:0] code_i,
    output rq_t        rq_o
);

    always_comb begin
        rq_o.kind = RQ_BAD;
        rq_o.idx  = 3'd0;
        if (code_i[7:5] == 3'b100) begin
            rq_o.kind = (code_i[4:0] == START_CODE) ? RQ_START : RQ_BAD;
        end else if (code_i[7:4] != 4'h0) begin
            rq_o.kind = RQ_BAD;
        end else if (code_i[1:0] == 2'b01) begin
            rq_o.kind = (code_i[3:2] == 2'b11) ? RQ_STATUS : RQ_PAIR;
            rq_o.idx  = {1'b0, code_i[3:2]};
        end else if (code_i[0] == 1'b0) begin
            rq_o.idx = code_i[3:1];
            if (code_i[3:1] == 3'b110)
                rq_o.kind = RQ_STATUS;
            else if (code_i[3:1] == 3'b111)
                rq_o.kind = RQ_BAD;
            else
                rq_o.kind = RQ_DIGIT;
        end
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int unsigned CYC_5C = 320000,
    parameter int unsigned CYC_5U = 160000,
    parameter int unsigned CYC_4C = 80000,
    parameter int unsigned CYC_4U = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic res_i,
    input  logic comp_i,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned MAX_A = (CYC_5C > CYC_5U) ? CYC_5C : CYC_5U;
    localparam int unsigned MAX_B = (CYC_4C > CYC_4U) ? CYC_4C : CYC_4U;
    localparam int unsigned MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW    = $clog2(MAXC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tq, td;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case ({res_i, comp_i})
            2'b11:   load_val = CW'(CYC_5C - 1);
            2'b10:   load_val = CW'(CYC_5U - 1);
            2'b01:   load_val = CW'(CYC_4C - 1);
            default: load_val = CW'(CYC_4U - 1);
        endcase
    end

    always_comb begin
        td = tq;
        if (tq.busy) begin
            if (tq.cnt == '0)
                td.busy = 1'b0;
            else
                td.cnt = tq.cnt - 1'b1;
        end else if (start_i) begin
            td.busy = 1'b1;
            td.cnt  = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tq <= '0;
        else
            tq <= td;
    end

    assign busy_o = tq.busy;
    assign done_o = tq.busy && (tq.cnt == '0);

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned CYC_5C     = 320000,
    parameter int unsigned CYC_5U     = 160000,
    parameter int unsigned CYC_4C     = 80000,
    parameter int unsigned CYC_4U     = 40000,
    parameter logic [4:0]  START_CODE = 5'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    output logic                 rx_ready,
    input  logic [7:0]           rx_data,
    input  logic                 rx_perr,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic [7:0]           tx_data,
    input  logic                 cfg_res,
    input  logic                 cfg_comp,
    input  logic [NDIG*DIGW-1:0] src_digits,
    input  logic                 src_cont
);

    typedef struct packed {
        logic [NDIG-1:0][DIGW-1:0] dig;
        logic                      upd;
        logic                      cont;
        logic                      res;
        logic                      comp;
        logic                      cfg_res;
        logic                      cfg_comp;
        logic                      rerr;
        logic                      perr;
        logic                      tx_v;
        logic                      tx_st;
        logic [7:0]                tx_d;
    } st_t;

    st_t        st_q, st_d;
    rq_t        rq;
    logic       conv_busy, conv_done, conv_start;
    logic       upd_flag;
    logic [2:0] lo_idx, hi_idx;

    adc_rd_decode #(.START_CODE(START_CODE)) u_dec (
        .code_i (rx_data),
        .rq_o   (rq)
    );

    adc_conv_timer #(
        .CYC_5C (CYC_5C),
        .CYC_5U (CYC_5U),
        .CYC_4C (CYC_4C),
        .CYC_4U (CYC_4U)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .res_i   (cfg_res),
        .comp_i  (cfg_comp),
        .busy_o  (conv_busy),
        .done_o  (conv_done)
    );

    assign lo_idx = {rq.idx[1:0], 1'b0};
    assign hi_idx = {rq.idx[1:0], 1'b1};

    always_comb begin
        logic acc;
        st_d       = st_q;
        conv_start = 1'b0;
        acc        = rx_valid && rx_ready;

        // reply leaves; a delivered status byte clears the error flags
        if (st_q.tx_v && tx_ready) begin
            st_d.tx_v = 1'b0;
            if (st_q.tx_st) begin
                st_d.rerr = 1'b0;
                st_d.perr = 1'b0;
            end
        end

        if (acc) begin
            if (rx_perr) begin
                st_d.perr = 1'b1;
            end else begin
                unique case (rq.kind)
                    RQ_PAIR: begin
                        st_d.tx_v  = 1'b1;
                        st_d.tx_st = 1'b0;
                        st_d.tx_d  = {st_q.dig[hi_idx], st_q.dig[lo_idx]};
                    end
                    RQ_DIGIT: begin
                        st_d.tx_v  = 1'b1;
                        st_d.tx_st = 1'b0;
                        st_d.tx_d  = {4'h0, st_q.dig[rq.idx]};
                    end
                    RQ_STATUS: begin
                        st_d.tx_v  = 1'b1;
                        st_d.tx_st = 1'b1;
                        st_d.tx_d  = pack_status(st_q.upd, st_q.cont, st_q.res,
                                                 st_q.comp, st_q.rerr, st_q.perr);
                    end
                    RQ_START: begin
                        if (!conv_busy) begin
                            conv_start    = 1'b1;
                            st_d.cfg_res  = cfg_res;
                            st_d.cfg_comp = cfg_comp;
                        end
                    end
                    default: st_d.rerr = 1'b1;
                endcase
            end
        end

        // publish: whole readable set replaced in one cycle
        if (conv_done) begin
            st_d.dig  = src_digits;
            st_d.cont = src_cont;
            st_d.res  = st_q.cfg_res;
            st_d.comp = st_q.cfg_comp;
            st_d.upd  = ~st_q.upd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rx_ready = !st_q.tx_v;
    assign tx_valid = st_q.tx_v;
    assign tx_data  = st_q.tx_d;
    assign upd_flag = st_q.upd;

endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       conv_done,
    input logic       upd_flag
);

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_no_rx_while_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    assert_bad_no_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && !rx_perr && rx_data[7:4] != 4'h0 && rx_data[7:5] != 3'b100
        |=> !tx_valid);

    assert_perr_no_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_perr |=> !tx_valid);

    assert_upd_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(upd_flag) |-> $past(conv_done));

    assert_status_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && !rx_perr && rx_data == 8'h0D
        |=> tx_valid && !tx_data[7] && !tx_data[5]);

endmodule

bind adc_readout_ctrl adc_rd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_perr   (rx_perr),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .conv_done (conv_done),
    .upd_flag  (upd_flag)
);

// File: tb/tb_adc_readout_ctrl.sv
module tb_adc_readout_ctrl;

    localparam int unsigned N5C = 64;
    localparam int unsigned N5U = 48;
    localparam int unsigned N4C = 32;
    localparam int unsigned N4U = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_perr = 1'b0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        cfg_res = 1'b0;
    logic        cfg_comp = 1'b0;
    logic [23:0] src_digits = 24'h0;
    logic        src_cont = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [3:0] md [6];
    logic m_upd, m_cont, m_res, m_comp, m_rerr, m_perr;

    always #4 clk = ~clk;

    adc_readout_ctrl #(
        .CYC_5C(N5C), .CYC_5U(N5U), .CYC_4C(N4C), .CYC_4U(N4U)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_perr(rx_perr),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .cfg_res(cfg_res), .cfg_comp(cfg_comp),
        .src_digits(src_digits), .src_cont(src_cont)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status();
        return {1'b0, m_upd, 1'b0, m_cont, m_res, m_comp, m_rerr, m_perr};
    endfunction

    // returns {has_reply, is_status, byte}
    function automatic logic [9:0] m_reply(input logic [7:0] b);
        if (b[7:4] != 4'h0) return 10'h0;
        if (b[1:0] == 2'b01) begin
            if (b[3:2] == 2'b11) return {2'b11, m_status()};
            return {2'b10, md[2*b[3:2]+1], md[2*b[3:2]]};
        end
        if (b[0] == 1'b0) begin
            if (b[3:1] == 3'd6) return {2'b11, m_status()};
            if (b[3:1] == 3'd7) return 10'h0;
            return {2'b10, 4'h0, md[b[3:1]]};
        end
        return 10'h0;
    endfunction

    task automatic send(input logic [7:0] b, input logic perr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_perr = perr;
        @(posedge clk);
        #1 rx_valid = 1'b0; rx_perr = 1'b0;
    endtask

    task automatic take(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk({req, " valid"}, {7'h0, tx_valid}, 8'h01);
        chk(req, tx_data, exp);
        tx_ready = 1'b1;
        @(posedge clk);
        #1 tx_ready = 1'b0;
    endtask

    task automatic none(input string req);
        @(negedge clk);
        chk({req, " no reply"}, {7'h0, tx_valid}, 8'h00);
    endtask

    // request with model update
    task automatic ask(input string req, input logic [7:0] b, input logic perr);
        logic [9:0] r;
        r = m_reply(b);
        send(b, perr);
        if (perr) begin
            m_perr = 1'b1;
            none(req);
        end else if (r[9]) begin
            take(req, r[7:0]);
            if (r[8]) begin m_rerr = 1'b0; m_perr = 1'b0; end
        end else begin
            m_rerr = 1'b1;
            none(req);
        end
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 6; k++) ask(req, {4'h0, 3'(k), 1'b0}, 1'b0);
        for (int p = 0; p < 3; p++) ask(req, {4'h0, 2'(p), 2'b01}, 1'b0);
    endtask

    task automatic conv(input logic res, input logic comp, input int n, input logic restart);
        logic c;
        for (int k = 0; k < 6; k++) src_digits[4*k +: 4] = 4'($urandom % 10);
        c = 1'($urandom);
        src_cont = c;
        cfg_res = res; cfg_comp = comp;
        send(8'h81, 1'b0);                       // accept edge E0
        cfg_res = ~res; cfg_comp = ~comp;        // R5: settings sampled at start only
        if (restart) begin
            repeat (2) @(posedge clk);           // E1, E2
            send(8'h81, 1'b0);                   // R7: ignored start at E3
            repeat (n - 4) @(posedge clk);       // up to E(n-1)
        end else begin
            repeat (n - 1) @(posedge clk);
        end
        ask("R6 old status on publish edge", 8'h0D, 1'b0);  // accepted at En
        for (int k = 0; k < 6; k++) md[k] = src_digits[4*k +: 4];
        m_upd = ~m_upd; m_cont = c; m_res = res; m_comp = comp;
        ask(restart ? "R7 status after restart" : "R5 status after latency", 8'h0C, 1'b0);
        read_all("R6 published digits");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 run did not end");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [7:0] held;
        void'($urandom(32'd1234));
        for (int k = 0; k < 6; k++) md[k] = 4'h0;
        {m_upd, m_cont, m_res, m_comp, m_rerr, m_perr} = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 tx_valid", {7'h0, tx_valid}, 8'h00);
        chk("R1 rx_ready", {7'h0, rx_ready}, 8'h01);
        ask("R1 status", 8'h0D, 1'b0);
        read_all("R1 digits");

        // R5, R6 each latency setting
        conv(1'b1, 1'b1, N5C, 1'b0);
        conv(1'b1, 1'b0, N5U, 1'b0);
        conv(1'b0, 1'b1, N4C, 1'b0);
        conv(1'b0, 1'b0, N4U, 1'b0);
        conv(1'b1, 1'b0, N5U, 1'b1);   // R7

        // R2 / R3 status aliases and R4 layout after conversions
        ask("R2 pair status", 8'h0D, 1'b0);
        ask("R3 single status", 8'h0C, 1'b0);

        // R8 unrecognized forms, R10 clear on status
        ask("R8 single 111", 8'h0E, 1'b0);
        ask("R10 status shows rerr", 8'h0C, 1'b0);
        ask("R10 status cleared", 8'h0C, 1'b0);
        ask("R8 pair 11 form", 8'h03, 1'b0);
        ask("R8 other command", 8'h9F, 1'b0);
        ask("R8 upper nibble", 8'h41, 1'b0);
        ask("R10 status shows rerr again", 8'h0D, 1'b0);
        // R9 parity
        ask("R9 parity byte", 8'h01, 1'b1);
        ask("R9 status perr", 8'h0D, 1'b0);
        ask("R10 perr cleared", 8'h0D, 1'b0);

        // R11 hold while not accepted
        send(8'h05, 1'b0);
        @(negedge clk);
        held = tx_data;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 rx_ready low", {7'h0, rx_ready}, 8'h00);
        chk("R11 data held", tx_data, held);
        take("R11 pair 2,3", {md[3], md[2]});

        // random mix of requests and parity faults
        for (int i = 0; i < 300; i++) begin
            b = 8'($urandom);
            if ($urandom % 2 == 0) b = {4'h0, b[3:0]};
            if (b == 8'h81) b = 8'h85;
            ask("R8 random request", b, ($urandom % 10) == 0);
        end
        ask("R10 final status", 8'h0D, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule